// File: doc/BRIEF.md
# Configurable UART Receive Channel

This block is one asynchronous serial receive channel. It watches a single line input, finds the start of each character, samples every following bit once at its centre and assembles an 8-bit word. The word is offered on a valid/ready output stream through a single-word holding register. Several settings are plain configuration pins, expected to stay steady while a character is arriving: the parity handling, one or two stop bits, which end of the word arrives first, the line polarity, and the bit-rate divisor with its power-of-two prescaler.

Each finished character gives a one-cycle transfer-end pulse. Three error conditions are kept as sticky flags: a bad stop bit, a wrong parity bit, and a word lost because the consumer had not taken the previous one. Any of the three raises a shared one-cycle error pulse in the same cycle as the transfer-end pulse. Each flag is cleared by its own bit of a clear input. The block produces no indication that the holding register is empty, apart from the low valid output.

Back-pressure rules: `rx_valid_o` stays high and `rx_data_o` stays steady until a cycle in which `rx_ready_i` is high. The line cannot be stalled, so a character that finishes while the register is still full replaces the old word and sets the overrun flag. A read and a finishing character in the same cycle is a clean hand-over, with no overrun.

Top module: `serial_rx_channel`

## Requirements
- R1: While `rst_n` is low and after its release, `rx_valid_o`, `xfer_done_o`, `xfer_err_o` and all three flags are 0.
- R2: A start is taken on a high-to-low change of the decoded line while idle. If the decoded line is high again at the start bit's midpoint, the channel returns to idle with no pulse and no flag.
- R3: Let P = 2^min(`cfg_psel_i`,11) and n = max(`cfg_div_n_i`,2). One bit lasts 2(n+1)P clocks. If the raw line is first seen low at clock edge k, the start is registered at edge k+2 (two-stage synchronizer). The frame then completes at edge k+2+(n+1)P(1+2B), where B counts the data, parity and stop bits.
- R4: The data field is 8 bits. With `cfg_msb_first_i`=0 the first data bit received is bit 0 of the word. With 1 it is bit 7.
- R5: With `cfg_invert_i`=1 the raw line is inverted before decoding, so the line idles low and a start bit is a high level.
- R6: `cfg_parity_i` encodings: 0 means no parity bit, 1 means a parity bit is present but never checked, 2 means even parity (ones in data plus parity bit form an even count), 3 means odd parity. A failed check sets `flag_parity_o`.
- R7: `cfg_two_stop_i`=1 adds a second stop bit and delays completion by one bit. Only the first stop bit is checked.
- R8: A first stop bit that decodes low sets `flag_framing_o`, and the word is still delivered.
- R9: A finished frame sets `rx_valid_o` with the word on `rx_data_o`. Valid and data hold until a cycle with `rx_ready_i` high.
- R10: If a frame finishes while `rx_valid_o` is high and `rx_ready_i` is low, the new word replaces the old one and `flag_overrun_o` is set. If ready is high in that cycle, there is no overrun.
- R11: `xfer_done_o` is high for exactly one cycle per completed frame. `xfer_err_o` is high in that same cycle when that frame sets any of the three flags.
- R12: Flags are sticky. `flag_clr_i` bit 0 clears framing, bit 1 clears parity and bit 2 clears overrun. A flag set in the same cycle as its clear ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Operating clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line_i | input | 1 | Raw serial line |
| cfg_parity_i | input | 2 | Parity handling (R6 encoding) |
| cfg_two_stop_i | input | 1 | 1 selects two stop bits |
| cfg_msb_first_i | input | 1 | 1 means the most significant bit arrives first |
| cfg_invert_i | input | 1 | 1 inverts line polarity |
| cfg_div_n_i | input | 7 | Divisor field n, bit = 2(n+1) prescaled ticks |
| cfg_psel_i | input | 4 | Prescaler exponent, 2^value clocks per tick |
| rx_valid_o | output | 1 | Holding register contains a word |
| rx_ready_i | input | 1 | Consumer takes the word |
| rx_data_o | output | 8 | Received word |
| xfer_done_o | output | 1 | One-cycle transfer-end pulse |
| xfer_err_o | output | 1 | One-cycle error pulse beside transfer end |
| flag_clr_i | input | 3 | Per-flag clear (bit 0 framing, 1 parity, 2 overrun) |
| flag_framing_o | output | 1 | Sticky framing error |
| flag_parity_o | output | 1 | Sticky parity error |
| flag_overrun_o | output | 1 | Sticky overrun |

## Verification
Two pairs of events can land on the same clock edge. A consumer read can coincide with the completion of the next frame, and a flag clear can coincide with a frame that sets that flag. The bench predicts the completion edge of every frame from the R3 formula, so it can raise `rx_ready_i` or a `flag_clr_i` bit for exactly that edge. The reference model judges the first case as a hand-over with no overrun and the second as set-wins. The valid, data, pulse and flag outputs are compared against the model on every cycle.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_ZERO = 2'd1,
    PAR_EVEN = 2'd2,
    PAR_ODD  = 2'd3
  } par_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP1,
    ST_STOP2
  } rx_state_e;

  typedef struct packed {
    logic framing;
    logic parity;
  } frame_err_t;

endpackage

// File: rtl/srx_line_front.sv
module srx_line_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic invert_i,
  output logic level_o,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  // synchronizer chain, first stage takes the raw line
  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b1;
          else        sync_q[0] <= line_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b1;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign level_o = sync_q[SYNC_STAGES-1] ^ invert_i;

  // last_q resets low so no edge is seen before the idle level appears
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= level_o;
  end

  assign fall_o = last_q & ~level_o;
endmodule

// File: rtl/srx_bit_timer.sv
module srx_bit_timer #(
  parameter int DIV_W         = 7,
  parameter int PRESC_LOG_MAX = 11,
  parameter int PSEL_W        = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              restart_i,
  input  logic              half_i,
  input  logic [DIV_W-1:0]  div_n_i,
  input  logic [PSEL_W-1:0] psel_i,
  output logic              sample_o
);
  localparam int                CNT_W    = DIV_W + 1;
  localparam logic [DIV_W-1:0]  MIN_N    = DIV_W'(2);
  localparam logic [PSEL_W-1:0] PSEL_TOP = PSEL_W'(PRESC_LOG_MAX);

  logic [DIV_W-1:0]         n_eff;
  logic [PSEL_W-1:0]        psel_eff;
  logic [PRESC_LOG_MAX-1:0] tick_mask;
  logic [PRESC_LOG_MAX-1:0] presc_q;
  logic [CNT_W-1:0]         target;
  logic [CNT_W-1:0]         bit_q;
  logic                     tick;

  always_comb begin
    n_eff     = (div_n_i < MIN_N) ? MIN_N : div_n_i;
    psel_eff  = (psel_i > PSEL_TOP) ? PSEL_TOP : psel_i;
    tick_mask = ~({PRESC_LOG_MAX{1'b1}} << psel_eff);
    // start bit: n+1 ticks to its middle; later bits: 2(n+1) ticks apart
    target    = half_i ? {1'b0, n_eff} : {n_eff, 1'b1};
    tick      = (presc_q == tick_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
    end else if (restart_i || !run_i || tick) begin
      presc_q <= '0;
    end else begin
      presc_q <= presc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= '0;
    end else if (restart_i || !run_i) begin
      bit_q <= '0;
    end else if (tick) begin
      if (bit_q == target) bit_q <= '0;
      else                 bit_q <= bit_q + 1'b1;
    end
  end

  assign sample_o = run_i & tick & (bit_q == target);
endmodule

// File: rtl/srx_frame_ctrl.sv
module srx_frame_ctrl
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              level_i,
  input  logic              fall_i,
  input  logic              sample_i,
  input  par_mode_e         par_mode_i,
  input  logic              two_stop_i,
  input  logic              msb_first_i,
  output logic              run_o,
  output logic              restart_o,
  output logic              half_o,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output frame_err_t        err_o
);
  localparam int                IDX_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0]  IDX_LAST = IDX_W'(DATA_W - 1);

  rx_state_e         state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] shift_q;
  logic              pbit_q;
  logic              fe_q;
  logic              data_par;

  assign restart_o = (state_q == ST_IDLE) & fall_i;
  assign run_o     = (state_q != ST_IDLE);
  assign half_o    = (state_q == ST_START);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      shift_q <= '0;
      pbit_q  <= 1'b0;
      fe_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (restart_o) state_q <= ST_START;
        end
        ST_START: begin
          if (sample_i) begin
            idx_q   <= '0;
            state_q <= level_i ? ST_IDLE : ST_DATA;
          end
        end
        ST_DATA: begin
          if (sample_i) begin
            if (msb_first_i) shift_q <= {shift_q[DATA_W-2:0], level_i};
            else             shift_q <= {level_i, shift_q[DATA_W-1:1]};
            idx_q <= idx_q + 1'b1;
            if (idx_q == IDX_LAST)
              state_q <= (par_mode_i == PAR_NONE) ? ST_STOP1 : ST_PARITY;
          end
        end
        ST_PARITY: begin
          if (sample_i) begin
            pbit_q  <= level_i;
            state_q <= ST_STOP1;
          end
        end
        ST_STOP1: begin
          if (sample_i) begin
            fe_q    <= ~level_i;
            state_q <= two_stop_i ? ST_STOP2 : ST_IDLE;
          end
        end
        ST_STOP2: begin
          if (sample_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    data_par = ^shift_q;
    done_o   = sample_i & (((state_q == ST_STOP1) & ~two_stop_i) |
                           (state_q == ST_STOP2));
    err_o.framing = (state_q == ST_STOP1) ? ~level_i : fe_q;
    case (par_mode_i)
      PAR_EVEN: err_o.parity = data_par ^ pbit_q;
      PAR_ODD:  err_o.parity = ~(data_par ^ pbit_q);
      default:  err_o.parity = 1'b0;
    endcase
  end

  assign data_o = shift_q;
endmodule

// File: rtl/srx_rx_buffer.sv
module srx_rx_buffer
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_done_i,
  input  logic [DATA_W-1:0] frame_data_i,
  input  frame_err_t        frame_err_i,
  input  logic              out_ready_i,
  input  logic [2:0]        clr_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              done_o,
  output logic              err_o,
  output logic              flag_framing_o,
  output logic              flag_parity_o,
  output logic              flag_overrun_o
);
  logic overrun_now;

  assign overrun_now = frame_done_i & out_valid_o & ~out_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_o    <= 1'b0;
      out_data_o     <= '0;
      done_o         <= 1'b0;
      err_o          <= 1'b0;
      flag_framing_o <= 1'b0;
      flag_parity_o  <= 1'b0;
      flag_overrun_o <= 1'b0;
    end else begin
      if (frame_done_i) begin
        out_valid_o <= 1'b1;
        out_data_o  <= frame_data_i;
      end else if (out_ready_i) begin
        out_valid_o <= 1'b0;
      end
      done_o <= frame_done_i;
      err_o  <= frame_done_i &
                (frame_err_i.framing | frame_err_i.parity | overrun_now);
      flag_framing_o <= (flag_framing_o & ~clr_i[0]) |
                        (frame_done_i & frame_err_i.framing);
      flag_parity_o  <= (flag_parity_o & ~clr_i[1]) |
                        (frame_done_i & frame_err_i.parity);
      flag_overrun_o <= (flag_overrun_o & ~clr_i[2]) | overrun_now;
    end
  end
endmodule

// File: rtl/serial_rx_channel.sv
module serial_rx_channel
  import serial_rx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int DIV_W         = 7,
  parameter int PRESC_LOG_MAX = 11,
  parameter int PSEL_W        = 4,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line_i,
  input  logic [1:0]        cfg_parity_i,
  input  logic              cfg_two_stop_i,
  input  logic              cfg_msb_first_i,
  input  logic              cfg_invert_i,
  input  logic [DIV_W-1:0]  cfg_div_n_i,
  input  logic [PSEL_W-1:0] cfg_psel_i,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              xfer_done_o,
  output logic              xfer_err_o,
  input  logic [2:0]        flag_clr_i,
  output logic              flag_framing_o,
  output logic              flag_parity_o,
  output logic              flag_overrun_o
);
  logic              level;
  logic              fall;
  logic              run;
  logic              restart;
  logic              half;
  logic              sample;
  logic              frame_done;
  logic [DATA_W-1:0] frame_data;
  frame_err_t        frame_err;
  par_mode_e         par_mode;

  assign par_mode = par_mode_e'(cfg_parity_i);

  srx_line_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_i   (rx_line_i),
    .invert_i (cfg_invert_i),
    .level_o  (level),
    .fall_o   (fall)
  );

  srx_bit_timer #(
    .DIV_W         (DIV_W),
    .PRESC_LOG_MAX (PRESC_LOG_MAX),
    .PSEL_W        (PSEL_W)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (run),
    .restart_i (restart),
    .half_i    (half),
    .div_n_i   (cfg_div_n_i),
    .psel_i    (cfg_psel_i),
    .sample_o  (sample)
  );

  srx_frame_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .level_i     (level),
    .fall_i      (fall),
    .sample_i    (sample),
    .par_mode_i  (par_mode),
    .two_stop_i  (cfg_two_stop_i),
    .msb_first_i (cfg_msb_first_i),
    .run_o       (run),
    .restart_o   (restart),
    .half_o      (half),
    .done_o      (frame_done),
    .data_o      (frame_data),
    .err_o       (frame_err)
  );

  srx_rx_buffer #(.DATA_W(DATA_W)) u_buf (
    .clk            (clk),
    .rst_n          (rst_n),
    .frame_done_i   (frame_done),
    .frame_data_i   (frame_data),
    .frame_err_i    (frame_err),
    .out_ready_i    (rx_ready_i),
    .clr_i          (flag_clr_i),
    .out_valid_o    (rx_valid_o),
    .out_data_o     (rx_data_o),
    .done_o         (xfer_done_o),
    .err_o          (xfer_err_o),
    .flag_framing_o (flag_framing_o),
    .flag_parity_o  (flag_parity_o),
    .flag_overrun_o (flag_overrun_o)
  );
endmodule

// File: rtl/serial_rx_channel_chk.sv
module serial_rx_channel_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid_o,
  input logic              rx_ready_i,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              xfer_done_o,
  input logic              xfer_err_o,
  input logic [2:0]        flag_clr_i,
  input logic              flag_framing_o,
  input logic              flag_parity_o,
  input logic              flag_overrun_o
);
  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done_o |=> !xfer_done_o);

  assert_err_beside_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_err_o |-> xfer_done_o);

  assert_done_fills_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done_o |-> rx_valid_o);

  assert_valid_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_o && !rx_ready_i) |=> rx_valid_o);

  assert_data_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_o && !rx_ready_i) |=> (xfer_done_o || $stable(rx_data_o)));

  assert_overrun_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_overrun_o) |-> (xfer_done_o && xfer_err_o));

  assert_framing_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_framing_o && !flag_clr_i[0]) |=> flag_framing_o);

  assert_parity_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_parity_o && !flag_clr_i[1]) |=> flag_parity_o);

  assert_overrun_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_overrun_o && !flag_clr_i[2]) |=> flag_overrun_o);
endmodule

bind serial_rx_channel serial_rx_channel_chk #(.DATA_W(DATA_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .rx_valid_o     (rx_valid_o),
  .rx_ready_i     (rx_ready_i),
  .rx_data_o      (rx_data_o),
  .xfer_done_o    (xfer_done_o),
  .xfer_err_o     (xfer_err_o),
  .flag_clr_i     (flag_clr_i),
  .flag_framing_o (flag_framing_o),
  .flag_parity_o  (flag_parity_o),
  .flag_overrun_o (flag_overrun_o)
);

// File: tb/sim_serial_rx_channel.sv
module sim_serial_rx_channel;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic [1:0] cfg_parity = 2'd0;
  logic       cfg_two_stop = 1'b0;
  logic       cfg_msb_first = 1'b0;
  logic       cfg_invert = 1'b0;
  logic [6:0] cfg_div_n = 7'd2;
  logic [3:0] cfg_psel = 4'd0;
  logic       rx_ready = 1'b0;
  logic [2:0] flag_clr = 3'b000;
  logic       rx_valid, xfer_done, xfer_err, f_fe, f_pe, f_ov;
  logic [7:0] rx_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_rx_channel u0 (
    .clk(clk), .rst_n(rst_n), .rx_line_i(rx_line),
    .cfg_parity_i(cfg_parity), .cfg_two_stop_i(cfg_two_stop),
    .cfg_msb_first_i(cfg_msb_first), .cfg_invert_i(cfg_invert),
    .cfg_div_n_i(cfg_div_n), .cfg_psel_i(cfg_psel),
    .rx_valid_o(rx_valid), .rx_ready_i(rx_ready), .rx_data_o(rx_data),
    .xfer_done_o(xfer_done), .xfer_err_o(xfer_err), .flag_clr_i(flag_clr),
    .flag_framing_o(f_fe), .flag_parity_o(f_pe), .flag_overrun_o(f_ov)
  );

  typedef struct {
    int         at;
    logic [7:0] data;
    bit         fe;
    bit         pe;
  } ev_t;

  ev_t        evq[$];
  int         cyc = 0;
  int         vectors = 0;
  int         miscompares = 0;
  bit         ready_hold = 0;
  int         ready_at = -1;
  int         clr_at = -1;
  logic [2:0] clr_mask = 3'b000;
  bit         checking = 0;

  bit         m_valid, m_done, m_err, m_fe, m_pe, m_ov;
  logic [7:0] m_data;

  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", req, what, cyc, act, exp);
    end
  endtask

  // behavioural reference, advanced once per rising edge
  always @(posedge clk) begin
    bit consumed, ovn;
    cyc++;
    if (!rst_n) begin
      m_valid = 0; m_done = 0; m_err = 0; m_fe = 0; m_pe = 0; m_ov = 0; m_data = 8'h00;
    end else begin
      m_done = 0;
      m_err  = 0;
      consumed = m_valid && rx_ready;
      if (flag_clr[0]) m_fe = 0;
      if (flag_clr[1]) m_pe = 0;
      if (flag_clr[2]) m_ov = 0;
      if (evq.size() > 0 && evq[0].at == cyc) begin
        ovn     = m_valid && !consumed;
        m_done  = 1;
        m_err   = evq[0].fe || evq[0].pe || ovn;
        m_valid = 1;
        m_data  = evq[0].data;
        if (evq[0].fe) m_fe = 1;
        if (evq[0].pe) m_pe = 1;
        if (ovn) m_ov = 1;
        void'(evq.pop_front());
      end else if (consumed) begin
        m_valid = 0;
      end
    end
  end

  // input pulses aimed at a chosen edge
  always @(negedge clk) begin
    rx_ready = ready_hold || (cyc + 1 == ready_at);
    flag_clr = (cyc + 1 == clr_at) ? clr_mask : 3'b000;
  end

  // comparison on every cycle
  always @(negedge clk) begin
    if (checking && rst_n) begin
      chk("R11", "xfer_done", xfer_done, m_done);
      chk("R11", "xfer_err", xfer_err, m_err);
      chk("R9", "rx_valid", rx_valid, m_valid);
      if (m_valid) chk("R4", "rx_data", rx_data, m_data);
      chk("R8", "flag_framing", f_fe, m_fe);
      chk("R6", "flag_parity", f_pe, m_pe);
      chk("R10", "flag_overrun", f_ov, m_ov);
    end
  end

  function automatic int bit_time();
    int n = (cfg_div_n < 7'd2) ? 2 : int'(cfg_div_n);
    int p = 1 << ((cfg_psel > 4'd11) ? 11 : int'(cfg_psel));
    return 2 * (n + 1) * p;
  endfunction

  task automatic idle(input int n);
    rx_line = cfg_invert ? 1'b0 : 1'b1;
    repeat (n) @(negedge clk);
  endtask

  // drives one character; called at a falling edge
  task automatic send(input logic [7:0] b, input bit pflip, input bit s1, input bit s2,
                      input bit rd_same, input logic [2:0] clr_same);
    bit   bits[$];
    int   bt = bit_time();
    int   half = bt / 2;
    int   nb;
    bit   p;
    ev_t  e;
    bits.push_back(1'b0);
    for (int i = 0; i < 8; i++) bits.push_back(cfg_msb_first ? b[7-i] : b[i]);
    p = (cfg_parity == 2'd2) ? ^b : (cfg_parity == 2'd3) ? ~^b : 1'b0;
    if (cfg_parity != 2'd0) bits.push_back(p ^ pflip);
    bits.push_back(s1);
    if (cfg_two_stop) bits.push_back(s2);
    nb = bits.size() - 1;
    e.at = cyc + 3 + half * (1 + 2 * nb);
    e.data = b;
    e.fe = !s1;
    e.pe = (cfg_parity >= 2'd2) && pflip;
    evq.push_back(e);
    if (rd_same) ready_at = e.at;
    if (clr_same != 3'b000) begin clr_at = e.at; clr_mask = clr_same; end
    foreach (bits[i]) begin
      rx_line = bits[i] ^ cfg_invert;
      repeat (bt) @(negedge clk);
    end
    idle(2 * bt);
  endtask

  task automatic set_cfg(input logic [1:0] par, input bit two, input bit msb, input bit inv,
                         input logic [6:0] n, input logic [3:0] ps);
    cfg_parity = par; cfg_two_stop = two; cfg_msb_first = msb;
    cfg_invert = inv; cfg_div_n = n; cfg_psel = ps;
    idle(4 * bit_time() + 8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "reset outputs", {rx_valid, xfer_done, xfer_err, f_fe, f_pe, f_ov}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "post-reset outputs", {rx_valid, xfer_done, xfer_err, f_fe, f_pe, f_ov}, 0);
    checking = 1;
    idle(10);

    // R3 R4: fastest rate, LSB first, no parity
    ready_hold = 1;
    set_cfg(2'd0, 0, 0, 0, 7'd2, 4'd0);
    send(8'hA5, 0, 1, 1, 0, 3'b000);
    send(8'h3C, 0, 1, 1, 0, 3'b000);
    // R4 R6: MSB first, even parity good then bad
    set_cfg(2'd2, 0, 1, 0, 7'd2, 4'd0);
    send(8'h81, 0, 1, 1, 0, 3'b000);
    send(8'h7E, 1, 1, 1, 0, 3'b000);
    flag_clr = 3'b010; @(negedge clk);
    // R6: odd parity good then bad
    set_cfg(2'd3, 0, 0, 0, 7'd4, 4'd0);
    send(8'h55, 0, 1, 1, 0, 3'b000);
    send(8'h55, 1, 1, 1, 0, 3'b000);
    // R6: appended bit never checked
    clr_at = cyc + 1; clr_mask = 3'b010; @(negedge clk);
    set_cfg(2'd1, 0, 0, 0, 7'd2, 4'd0);
    send(8'h0F, 1, 1, 1, 0, 3'b000);
    // R8: bad stop bit
    set_cfg(2'd0, 0, 0, 0, 7'd2, 4'd0);
    send(8'hE7, 0, 0, 1, 0, 3'b000);
    clr_at = cyc + 1; clr_mask = 3'b001; @(negedge clk);
    // R7: two stop bits, only the first checked
    set_cfg(2'd0, 1, 0, 0, 7'd2, 4'd0);
    send(8'h42, 0, 1, 0, 0, 3'b000);
    send(8'h24, 0, 0, 1, 0, 3'b000);
    clr_at = cyc + 1; clr_mask = 3'b001; @(negedge clk);
    // R5: inverted line
    set_cfg(2'd2, 0, 0, 1, 7'd3, 4'd0);
    send(8'hC3, 0, 1, 1, 0, 3'b000);
    // R2: short low pulse rejected at start midpoint
    set_cfg(2'd0, 0, 0, 0, 7'd2, 4'd0);
    rx_line = 1'b0; repeat (2) @(negedge clk);
    idle(40);
    chk("R2", "no frame after glitch", rx_valid, 0);
    // R3: prescaler and divisor clamp
    set_cfg(2'd0, 0, 0, 0, 7'd3, 4'd2);
    send(8'h9A, 0, 1, 1, 0, 3'b000);
    set_cfg(2'd0, 0, 0, 0, 7'd0, 4'd0);
    send(8'h11, 0, 1, 1, 0, 3'b000);
    // R10: overrun with no reader
    ready_hold = 0;
    send(8'h01, 0, 1, 1, 0, 3'b000);
    send(8'h02, 0, 1, 1, 0, 3'b000);
    chk("R10", "overwritten word", rx_data, 8'h02);
    clr_at = cyc + 1; clr_mask = 3'b100; @(negedge clk);
    // R10: read in the completion cycle gives no overrun
    send(8'h03, 0, 1, 1, 1, 3'b000);
    chk("R10", "no overrun on same-cycle read", f_ov, 0);
    // R12: clear and set on the same edge, set wins
    set_cfg(2'd2, 0, 0, 0, 7'd2, 4'd0);
    send(8'h6B, 1, 1, 1, 1, 3'b010);
    chk("R12", "parity flag kept", f_pe, 1);
    clr_at = cyc + 1; clr_mask = 3'b111; @(negedge clk);
    @(negedge clk);
    chk("R12", "flags cleared", {f_fe, f_pe, f_ov}, 0);
    ready_hold = 1;
    idle(20);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule